// File: doc/BRIEF.md
# Nine-bit multiprocessor serial receiver

This block receives asynchronous serial frames, either with eight data bits or with nine. Each bit time spans sixteen ticks of an external oversample strobe. The receiver waits on an idle-high line for a high-to-low transition. It confirms the start bit with a single sample at mid-bit, then shifts in the remaining bits least significant bit first. A marker bit travels through the shift register, and its arrival at the top marks the last bit of the frame. On that last bit the receiver decides whether to deliver the frame.

A frame is delivered only if the ready flag is clear. In multiprocessor mode it must also have its final bit high. In nine-bit frames the final bit is the ninth data bit, which marks an address. In eight-bit frames the final bit is the stop bit, which marks a valid frame. A frame that fails this gate is dropped without any trace. Software clears the ready flag with a one-cycle strobe.

The intended use is a shared bus with one master and several listeners. Each listener keeps multiprocessor mode on and is interrupted only by address frames. Once a listener sees its own address, it turns the mode off and takes the data frames that follow.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset `rdy_o`, `bit9_o` and `data_o` are all 0.
- R2: With `nine_bit_i`=1 and `mp_en_i`=0, a frame is delivered. The frame is a start bit (0), eight data bits least significant first, a ninth bit and a stop bit (1). The eight data bits appear on `data_o` (the first received bit becomes `data_o[0]`), the ninth bit appears on `bit9_o`, and `rdy_o` is set. `rdy_o` is still 0 after the eighth data bit.
- R3: With `nine_bit_i`=0 and `mp_en_i`=0, a frame is a start bit followed by eight data bits and a stop bit. The data reaches `data_o`, and the sampled stop bit level (1 or 0) is placed on `bit9_o`.
- R4: A low pulse on `rx_i` that is high again at the middle of the start bit is taken as a false start. Nothing is delivered, and a proper frame that follows is received.
- R5: A frame that completes while `rdy_o`=1 is discarded: `data_o`, `bit9_o` and `rdy_o` are unchanged.
- R6: With `mp_en_i`=1 in nine-bit mode, a frame whose ninth bit is 0 is discarded, and a frame whose ninth bit is 1 is delivered.
- R7: With `mp_en_i`=1 in eight-bit mode, a frame whose stop bit is sampled low is discarded, and a frame with a high stop bit is delivered.
- R8: A one-cycle `clr_rdy_i` pulse clears `rdy_o` on the next clock edge and leaves `data_o` unchanged.
- R9: In nine-bit mode the receiver resumes hunting one bit time after the ninth bit. A frame whose start bit directly follows the previous stop bit is received.
- R10: `data_o` and `bit9_o` change only on the clock edge at which `rdy_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | One-cycle oversample strobe, 16 per bit time |
| nine_bit_i | input | 1 | 1: nine data bits per frame, 0: eight |
| mp_en_i | input | 1 | Multiprocessor gate: deliver only frames whose final bit is 1 |
| clr_rdy_i | input | 1 | One-cycle strobe that clears the ready flag |
| data_o | output | 8 | Received data byte |
| bit9_o | output | 1 | Ninth bit (stop bit in eight-bit mode) |
| rdy_o | output | 1 | Receive-ready flag |

## Verification
The falling edge on `rx_i` needs two synchronizer stages before it is seen, so the hunt leaves idle three clock edges after the line drops. The start sample falls on the 8th tick after that. Data samples fall on ticks 24, 40, … 136. The final bit is sampled, and `rdy_o` rises, on the edge of the 152nd tick. A clear strobe acts on the next edge. The bench drives inputs and samples outputs on falling clock edges. It checks that `rdy_o` is still low after the eighth data bit. It checks delivered values only after the whole stop bit plus an idle bit time, which is well past the 152nd tick. A back-to-back frame confirms that the hunt resumes at mid-stop.

// File: rtl/mp_uart_rx_pkg.sv
package mp_uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_WAIT
  } rx_state_e;
endpackage

// File: rtl/mp_uart_rx_sync.sv
module mp_uart_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rx_s_o = sync_q;
  assign fall_o = prev_q & ~sync_q;
endmodule

// File: rtl/mp_uart_rx_ctrl.sv
module mp_uart_rx_ctrl
  import mp_uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fall_i,
  input  logic rx_i,
  input  logic nine_bit_i,
  input  logic marker_i,
  output logic preload_o,
  output logic shift_o,
  output logic final_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned MID   = OVS / 2;

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              nine_q, nine_d;
  logic [CNT_W-1:0]  wait_last;

  // nine-bit: a full bit after the ninth bit (mid-stop); eight-bit: to end of stop
  assign wait_last = nine_q ? CNT_W'(OVS - 1) : CNT_W'(MID - 1);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    nine_d    = nine_q;
    preload_o = 1'b0;
    shift_o   = 1'b0;
    final_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall_i) begin
          state_d = ST_START;
          cnt_d   = '0;
          nine_d  = nine_bit_i;
        end
      end
      ST_START: begin
        if (tick_i) begin
          if (cnt_q == CNT_W'(MID - 1)) begin
            cnt_d = '0;
            if (rx_i) begin
              state_d = ST_IDLE;       // false start
            end else begin
              state_d   = ST_DATA;
              preload_o = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tick_i) begin
          if (cnt_q == CNT_W'(OVS - 1)) begin
            cnt_d = '0;
            if (!marker_i) begin
              final_o = 1'b1;
              state_d = ST_WAIT;
            end else begin
              shift_o = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (tick_i) begin
          if (cnt_q == wait_last) begin
            cnt_d   = '0;
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      nine_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      nine_q  <= nine_d;
    end
  end
endmodule

// File: rtl/mp_uart_rx_shreg.sv
module mp_uart_rx_shreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              preload_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic              marker_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int unsigned SR_W = DATA_W + 1;

  logic [SR_W-1:0] sr_q;

  // start bit (0) enters below a field of ones; it reaches the top after DATA_W shifts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '1;
    end else if (preload_i) begin
      sr_q <= {{DATA_W{1'b1}}, 1'b0};
    end else if (shift_i) begin
      sr_q <= {sr_q[SR_W-2:0], bit_i};
    end
  end

  assign marker_o = sr_q[SR_W-1];

  // first bit received sits highest; it is the LSB of the byte
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign byte_o[i] = sr_q[DATA_W-1-i];
  end
endmodule

// File: rtl/mp_uart_rx_out.sv
module mp_uart_rx_out #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              final_i,
  input  logic              bit_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              mp_en_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              rdy_o
);
  logic load;

  assign load = final_i & ~rdy_o & (~mp_en_i | bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      bit9_o <= 1'b0;
      rdy_o  <= 1'b0;
    end else if (load) begin
      data_o <= byte_i;
      bit9_o <= bit_i;
      rdy_o  <= 1'b1;
    end else if (clr_i) begin
      rdy_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              nine_bit_i,
  input  logic              mp_en_i,
  input  logic              clr_rdy_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              rdy_o
);
  logic              rx_s, fall;
  logic              preload, shift, final_bit, marker;
  logic [DATA_W-1:0] byte_w;

  mp_uart_rx_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .rx_s_o (rx_s),
    .fall_o (fall)
  );

  mp_uart_rx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .fall_i     (fall),
    .rx_i       (rx_s),
    .nine_bit_i (nine_bit_i),
    .marker_i   (marker),
    .preload_o  (preload),
    .shift_o    (shift),
    .final_o    (final_bit)
  );

  mp_uart_rx_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .preload_i (preload),
    .shift_i   (shift),
    .bit_i     (rx_s),
    .marker_o  (marker),
    .byte_o    (byte_w)
  );

  mp_uart_rx_out #(.DATA_W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .final_i (final_bit),
    .bit_i   (rx_s),
    .byte_i  (byte_w),
    .mp_en_i (mp_en_i),
    .clr_i   (clr_rdy_i),
    .data_o  (data_o),
    .bit9_o  (bit9_o),
    .rdy_o   (rdy_o)
  );
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mp_en_i,
  input logic              clr_rdy_i,
  input logic [DATA_W-1:0] data_o,
  input logic              bit9_o,
  input logic              rdy_o
);
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(rdy_o) |-> $stable({data_o, bit9_o})) else $error("out changed without rdy rise"); // R10

  AST_CLR_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_rdy_i && rdy_o) |=> !rdy_o) else $error("clear ignored"); // R8

  AST_RDY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !clr_rdy_i) |=> (rdy_o && $stable(data_o))) else $error("busy frame overwrote"); // R5

  AST_MP_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mp_en_i) && $rose(rdy_o)) |-> bit9_o) else $error("mp gate leaked"); // R6
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mp_en_i   (mp_en_i),
  .clr_rdy_i (clr_rdy_i),
  .data_o    (data_o),
  .bit9_o    (bit9_o),
  .rdy_o     (rdy_o)
);

// File: tb/mp_uart_rx_bench.sv
module mp_uart_rx_bench;
  localparam int BIT_CLK = 64;   // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic       nine_bit = 1'b1;
  logic       mp_en = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] data;
  logic       bit9;
  logic       rdy;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic [7:0] snap;

  always #10 clk = ~clk;  // 50 MHz

  mp_uart_rx u_mp_uart_rx (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .rx_i       (rx),
    .tick_i     (tick),
    .nine_bit_i (nine_bit),
    .mp_en_i    (mp_en),
    .clr_rdy_i  (clr),
    .data_o     (data),
    .bit9_o     (bit9),
    .rdy_o      (rdy)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(input logic b);
    rx = b;
    wait_clk(BIT_CLK);
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    wait_clk(1);
    clr = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop,
                            input logic clr_mid, input logic mid_chk);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (mid_chk) check("R2 rdy low after 8th data bit", {31'd0, rdy}, 32'd0);
    if (nine_bit) drive_bit(b9);
    rx = stop;
    if (clr_mid) begin
      wait_clk(8);
      snap = data;
      pulse_clr();
      wait_clk(BIT_CLK - 9);
    end else begin
      wait_clk(BIT_CLK);
    end
    rx = 1'b1;
  endtask

  task automatic clear_and_check(input string req, input logic [7:0] exp_d);
    pulse_clr();
    check(req, {31'd0, rdy}, 32'd0);
    check(req, {24'd0, data}, {24'd0, exp_d});
  endtask

  task automatic t_reset();
    check("R1 rdy", {31'd0, rdy}, 32'd0);
    check("R1 bit9", {31'd0, bit9}, 32'd0);
    check("R1 data", {24'd0, data}, 32'd0);
  endtask

  task automatic t_nine_basic();
    nine_bit = 1'b1; mp_en = 1'b0;
    send_frame(8'hA3, 1'b0, 1'b1, 1'b0, 1'b1);
    wait_clk(BIT_CLK);
    check("R2 data", {24'd0, data}, 32'hA3);
    check("R2 bit9", {31'd0, bit9}, 32'd0);
    check("R2 rdy", {31'd0, rdy}, 32'd1);
    clear_and_check("R8 clear", 8'hA3);
  endtask

  task automatic t_busy();
    send_frame(8'h3C, 1'b1, 1'b1, 1'b0, 1'b0);
    wait_clk(BIT_CLK);
    check("R2 data 3C", {24'd0, data}, 32'h3C);
    check("R2 bit9 set", {31'd0, bit9}, 32'd1);
    send_frame(8'h55, 1'b0, 1'b1, 1'b0, 1'b0);
    wait_clk(BIT_CLK);
    check("R5 data kept", {24'd0, data}, 32'h3C);
    check("R5 bit9 kept", {31'd0, bit9}, 32'd1);
    check("R5 rdy kept", {31'd0, rdy}, 32'd1);
    clear_and_check("R8 clear after busy", 8'h3C);
  endtask

  task automatic t_eight();
    nine_bit = 1'b0; mp_en = 1'b0;
    send_frame(8'h96, 1'b0, 1'b1, 1'b0, 1'b0);
    wait_clk(BIT_CLK);
    check("R3 data", {24'd0, data}, 32'h96);
    check("R3 stop to bit9", {31'd0, bit9}, 32'd1);
    clear_and_check("R8 clear", 8'h96);
    send_frame(8'h0F, 1'b1, 1'b0, 1'b0, 1'b0);
    wait_clk(BIT_CLK);
    check("R3 low-stop data", {24'd0, data}, 32'h0F);
    check("R3 low stop to bit9", {31'd0, bit9}, 32'd0);
    check("R3 rdy", {31'd0, rdy}, 32'd1);
    clear_and_check("R8 clear", 8'h0F);
  endtask

  task automatic t_false_start();
    nine_bit = 1'b1; mp_en = 1'b0;
    rx = 1'b0;
    wait_clk(16);
    rx = 1'b1;
    wait_clk(4 * BIT_CLK);
    check("R4 no delivery", {31'd0, rdy}, 32'd0);
    check("R4 data kept", {24'd0, data}, 32'h0F);
    send_frame(8'h5A, 1'b1, 1'b1, 1'b0, 1'b0);
    wait_clk(BIT_CLK);
    check("R4 following frame", {24'd0, data}, 32'h5A);
    check("R4 following rdy", {31'd0, rdy}, 32'd1);
    clear_and_check("R8 clear", 8'h5A);
  endtask

  task automatic t_mp9();
    nine_bit = 1'b1; mp_en = 1'b1;
    send_frame(8'h11, 1'b0, 1'b1, 1'b0, 1'b0);
    wait_clk(BIT_CLK);
    check("R6 data frame dropped rdy", {31'd0, rdy}, 32'd0);
    check("R6 data frame dropped data", {24'd0, data}, 32'h5A);
    send_frame(8'h42, 1'b1, 1'b1, 1'b0, 1'b0);
    wait_clk(BIT_CLK);
    check("R6 address taken rdy", {31'd0, rdy}, 32'd1);
    check("R6 address data", {24'd0, data}, 32'h42);
    check("R6 address bit9", {31'd0, bit9}, 32'd1);
    clear_and_check("R8 clear", 8'h42);
  endtask

  task automatic t_mp8();
    nine_bit = 1'b0; mp_en = 1'b1;
    send_frame(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0);
    wait_clk(BIT_CLK);
    check("R7 bad stop dropped rdy", {31'd0, rdy}, 32'd0);
    check("R7 bad stop dropped data", {24'd0, data}, 32'h42);
    send_frame(8'h24, 1'b0, 1'b1, 1'b0, 1'b0);
    wait_clk(BIT_CLK);
    check("R7 good stop rdy", {31'd0, rdy}, 32'd1);
    check("R7 good stop data", {24'd0, data}, 32'h24);
    clear_and_check("R8 clear", 8'h24);
  endtask

  task automatic t_b2b();
    nine_bit = 1'b1; mp_en = 1'b0;
    send_frame(8'h81, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R9 first frame", {24'd0, snap}, 32'h81);
    send_frame(8'h7E, 1'b0, 1'b1, 1'b0, 1'b0);
    wait_clk(BIT_CLK);
    check("R9 second frame data", {24'd0, data}, 32'h7E);
    check("R9 second frame bit9", {31'd0, bit9}, 32'd0);
    check("R9 second frame rdy", {31'd0, rdy}, 32'd1);
  endtask

  initial begin
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(2);
    t_reset();
    t_nine_basic();
    t_busy();
    t_eight();
    t_false_start();
    t_mp9();
    t_mp8();
    t_b2b();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule